// File: doc/BRIEF.md
# Four-Phase Clock-Domain Word Link

This block carries single data words from a sending clock domain to a receiving clock domain whose clock has no fixed relation to the first. Neither side relies on the skew between the clocks or on where the two halves are placed. That makes the link suitable for a connection between separate devices. The sending half loads a word onto a shared data bus and then raises a request line. The receiving half takes the word and raises an acknowledge line. Both lines then return to zero, in strict order, before the next word may start.

Each half sees the other side's control line only through its own multi-stage synchronizer. The data bus itself is never synchronized. It is sampled only once the synchronized request proves that the bus has settled. On each side, local logic talks to the link through a valid/ready port. The receiving port applies backpressure: a held word blocks the capture of the next one. Each clock domain takes an asynchronous active-low reset, and each half releases that reset synchronously to its own clock.

Top module: `hs_link`

## Requirements
- R1: While a domain's reset is held, and after it is released with no traffic, `s_ready` is low during reset and high afterwards, `m_valid` is low, and `link_req` and `link_ack` are both low.
- R2: A word is accepted on a `tx_clk` edge where `s_valid` and `s_ready` are both high. After that edge, `link_data` carries the word and `s_ready` is low. `link_req` stays low for that one cycle and is high after the following `tx_clk` edge.
- R3: `link_data` does not change while `link_req` or `link_ack` is high.
- R4: `link_ack` rises only while `link_req` is high. When it rises, `m_valid` is high and `m_data` equals the word on the bus.
- R5: The two link lines follow a strict four-phase order. `link_req` rises only while `link_ack` is low and falls only while `link_ack` is high. `link_ack` falls only while `link_req` is low.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` stays constant. A further request on the link receives no acknowledge until the held word is taken, which happens on an `rx_clk` edge with `m_valid` and `m_ready` both high.
- R7: Every accepted word is delivered exactly once, in acceptance order, for any ratio of the two clock periods.
- R8: Each delivered word corresponds to exactly one rising edge of `link_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Sending domain clock |
| tx_rst_n | input | 1 | Sending domain reset, active low, asynchronous assert |
| s_valid | input | 1 | Sender local port: word offered |
| s_ready | output | 1 | Sender local port: link can take a word |
| s_data | input | DATA_W | Sender local port: word |
| rx_clk | input | 1 | Receiving domain clock |
| rx_rst_n | input | 1 | Receiving domain reset, active low, asynchronous assert |
| m_valid | output | 1 | Receiver local port: word held |
| m_ready | input | 1 | Receiver local port: consumer takes the word |
| m_data | output | DATA_W | Receiver local port: word |
| link_req | output | 1 | Request line driven by the sending half |
| link_ack | output | 1 | Acknowledge line driven by the receiving half |
| link_data | output | DATA_W | Shared data bus driven by the sending half |

## Verification
The hardest state to reach is a request that stays pending on the link, unacknowledged, while the receiver still holds an earlier word. Reaching it needs a completed transfer followed by a second accepted word, with the consumer held off long enough for several synchronizer delays to pass. The stimulus holds `m_ready` low, pushes two words back to back, and waits many receive cycles. It then checks that the first word is held and that the request goes unanswered before the consumer is released. Streams then run with the receive clock at several periods above and below the send clock, some with the consumer ready at random. A scoreboard and a counter of request edges catch any lost or repeated word.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SETUP = 2'd1,
    TX_REQ   = 2'd2,
    TX_DROP  = 2'd3
  } tx_state_e;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_ACK  = 1'b1
  } rx_state_e;

endpackage

// File: rtl/hs_sync.sv
// Multi-stage synchronizer for one control bit entering this clock domain.
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hs_rst_sync.sv
// Reset asserts at once and is released on this domain's clock.
module hs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb ff_d = 1'b1;
    end else begin : g_multi
      always_comb ff_d = {ff_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) ff_q <= '0;
    else         ff_q <= ff_d;
  end

  assign rst_n = ff_q[STAGES-1];

endmodule

// File: rtl/hs_tx.sv
// Sending half: loads the bus, then walks request through its four phases.
module hs_tx
  import hs_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              ack_in,
  output logic              req_out,
  output logic [DATA_W-1:0] data_out
);

  tx_state_e         state_q, state_d;
  logic              req_q, req_d;
  logic [DATA_W-1:0] data_q;
  logic              load_en;
  logic              ack_sync;

  hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ack_in),
    .q    (ack_sync)
  );

  assign s_ready = rst_n && (state_q == TX_IDLE) && !ack_sync;

  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (s_valid && s_ready) begin
          load_en = 1'b1;
          state_d = TX_SETUP;
        end
      end
      TX_SETUP: state_d = TX_REQ;
      TX_REQ:   if (ack_sync)  state_d = TX_DROP;
      TX_DROP:  if (!ack_sync) state_d = TX_IDLE;
      default:  state_d = TX_IDLE;
    endcase
    req_d = (state_d == TX_REQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_en) data_q <= s_data;
  end

  assign req_out  = req_q;
  assign data_out = data_q;

  // R3: bus frozen while the request or its acknowledge is live
  assert_bus_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q || ack_sync) |-> $stable(data_q));

  // R5: request rises only after acknowledge has been seen low
  assert_req_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !ack_sync);

  // R5: request drops only after acknowledge has been seen high
  assert_req_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(ack_sync));

  // R2: after an acceptance the local port closes for the transfer
  assert_accept_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (!s_ready && !req_q));

endmodule

// File: rtl/hs_rx.sv
// Receiving half: captures the settled bus and answers with acknowledge.
module hs_rx
  import hs_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              ack_out,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);

  rx_state_e         state_q, state_d;
  logic              ack_q, ack_d;
  logic              hold_q, hold_d;
  logic [DATA_W-1:0] word_q;
  logic              cap_en;
  logic              req_sync;

  hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req_in),
    .q    (req_sync)
  );

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (req_sync && !hold_q) begin
          cap_en  = 1'b1;
          state_d = RX_ACK;
        end
      end
      RX_ACK:  if (!req_sync) state_d = RX_IDLE;
      default: state_d = RX_IDLE;
    endcase
    ack_d = (state_d == RX_ACK);
  end

  always_comb begin
    hold_d = hold_q;
    if (cap_en)                hold_d = 1'b1;
    else if (hold_q && m_ready) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      ack_q   <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      hold_q  <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (cap_en) word_q <= data_in;
  end

  assign ack_out = ack_q;
  assign m_valid = hold_q;
  assign m_data  = word_q;

  // R4: acknowledge rises together with a freshly presented word
  assert_ack_with_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> (m_valid && m_data == data_in));

  // R5: acknowledge falls only once the request is seen low
  assert_ack_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> !req_sync);

  // R6: held word is kept until taken
  assert_hold_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

endmodule

// File: rtl/hs_link.sv
module hs_link #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              tx_clk,
  input  logic              tx_rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              rx_clk,
  input  logic              rx_rst_n,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              link_req,
  output logic              link_ack,
  output logic [DATA_W-1:0] link_data
);

  localparam int RST_STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic tx_rst_sync_n;
  logic rx_rst_sync_n;

  hs_rst_sync #(.STAGES(RST_STAGES)) u_tx_rst (
    .clk   (tx_clk),
    .arst_n(tx_rst_n),
    .rst_n (tx_rst_sync_n)
  );

  hs_rst_sync #(.STAGES(RST_STAGES)) u_rx_rst (
    .clk   (rx_clk),
    .arst_n(rx_rst_n),
    .rst_n (rx_rst_sync_n)
  );

  hs_tx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk     (tx_clk),
    .rst_n   (tx_rst_sync_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .ack_in  (link_ack),
    .req_out (link_req),
    .data_out(link_data)
  );

  hs_rx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk    (rx_clk),
    .rst_n  (rx_rst_sync_n),
    .req_in (link_req),
    .data_in(link_data),
    .ack_out(link_ack),
    .m_valid(m_valid),
    .m_ready(m_ready),
    .m_data (m_data)
  );

endmodule

// File: tb/tb_hs_link.sv
`timescale 1ns/1ps
module tb_hs_link;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 32;

  logic          tx_clk = 1'b0;
  logic          rx_clk = 1'b0;
  logic          tx_rst_n = 1'b0;
  logic          rx_rst_n = 1'b0;
  logic          s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          m_ready = 1'b0;
  logic          s_ready, m_valid, link_req, link_ack;
  logic [DW-1:0] m_data, link_data;

  int rx_half = 7;
  int rdy_mode = 1;   // 0 hold low, 1 always high, 2 random
  int checks = 0;
  int failures = 0;
  bit mon_en = 1'b0;
  int delivered = 0;
  int req_rises = 0;
  logic [DW-1:0] exp_q[$];

  hs_link #(.DATA_W(DW), .SYNC_STAGES(2)) dut (
    .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .link_req(link_req), .link_ack(link_ack),
    .link_data(link_data)
  );

  initial forever #(CLK_PERIOD/2) tx_clk = ~tx_clk;
  initial forever #(rx_half) rx_clk = ~rx_clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // consumer readiness, driven just after each rx edge
  initial forever begin
    @(posedge rx_clk);
    #1;
    if (rdy_mode == 0)      m_ready = 1'b0;
    else if (rdy_mode == 1) m_ready = 1'b1;
    else                    m_ready = 1'($urandom % 2);
  end

  // sender side acceptance monitor
  initial forever begin
    @(negedge tx_clk);
    if (mon_en && s_valid && s_ready) exp_q.push_back(s_data);
  end

  // receiver side scoreboard (R7)
  initial forever begin
    @(negedge rx_clk);
    if (mon_en && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "word delivered with none pending", m_data, '0);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(m_data == e, "R7", "delivered word order/content", m_data, e);
      end
      delivered++;
    end
  end

  // four-phase ordering monitors (R5, R4, R3)
  always @(posedge link_req) if (mon_en) begin
    req_rises++;
    chk(!link_ack, "R5", "req rose while ack high", {31'd0, link_ack}, '0);
  end
  always @(negedge link_req) if (mon_en)
    chk(link_ack, "R5", "req fell while ack low", {31'd0, link_ack}, 1);
  always @(posedge link_ack) if (mon_en)
    chk(link_req, "R4", "ack rose while req low", {31'd0, link_req}, 1);
  always @(negedge link_ack) if (mon_en)
    chk(!link_req, "R5", "ack fell while req high", {31'd0, link_req}, '0);
  always @(link_data) if (mon_en)
    chk(!(link_req || link_ack), "R3", "bus changed during transfer",
        {30'd0, link_req, link_ack}, '0);

  task automatic send(input logic [DW-1:0] w);
    @(posedge tx_clk); #1;
    s_valid = 1'b1;
    s_data  = w;
    do @(negedge tx_clk); while (!s_ready);
    @(posedge tx_clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    int n = 0;
    while ((exp_q.size() != 0 || link_req || link_ack || m_valid) && n < 20000) begin
      @(negedge tx_clk);
      n++;
    end
    chk(n < 20000, req, "link drained", n, 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge tx_clk);
    chk(!s_ready, "R1", "s_ready during reset", {31'd0, s_ready}, '0);
    tx_rst_n = 1'b1;
    rx_rst_n = 1'b1;
    repeat (6) @(negedge tx_clk);
    repeat (6) @(negedge rx_clk);
    @(negedge tx_clk);
    chk(s_ready, "R1", "s_ready after reset", {31'd0, s_ready}, 1);
    chk(!m_valid, "R1", "m_valid after reset", {31'd0, m_valid}, '0);
    chk(!link_req && !link_ack, "R1", "link lines after reset",
        {30'd0, link_req, link_ack}, '0);
    mon_en = 1'b1;
  endtask

  task automatic test_single();
    logic [DW-1:0] w = 32'hA5C3_0F11;
    int d0 = delivered;
    int n = 0;
    rdy_mode = 1;
    @(posedge tx_clk); #1;
    s_valid = 1'b1;
    s_data  = w;
    @(negedge tx_clk);
    chk(s_ready, "R2", "ready to accept", {31'd0, s_ready}, 1);
    @(posedge tx_clk); #1;
    s_valid = 1'b0;
    s_data  = '1;
    @(negedge tx_clk);
    chk(link_data == w, "R2", "bus loaded after accept", link_data, w);
    chk(!s_ready, "R2", "s_ready low after accept", {31'd0, s_ready}, '0);
    chk(!link_req, "R2", "req low in setup cycle", {31'd0, link_req}, '0);
    @(negedge tx_clk);
    chk(link_req, "R2", "req high one cycle later", {31'd0, link_req}, 1);
    while (!link_ack && n < 1000) begin @(negedge rx_clk); n++; end
    @(negedge rx_clk);
    chk(m_data == w, "R4", "captured word at ack", m_data, w);
    wait_drain("R4");
    chk(delivered == d0 + 1, "R4", "single delivery count", delivered, d0 + 1);
  endtask

  task automatic test_backpressure();
    logic [DW-1:0] w1 = 32'h1111_2222;
    logic [DW-1:0] w2 = 32'h3333_4444;
    int d0 = delivered;
    rdy_mode = 0;
    repeat (2) @(negedge rx_clk);
    send(w1);
    send(w2);
    repeat (60) @(negedge rx_clk);
    chk(m_valid, "R6", "word held under backpressure", {31'd0, m_valid}, 1);
    chk(m_data == w1, "R6", "held word unchanged", m_data, w1);
    chk(link_req, "R6", "second request pending", {31'd0, link_req}, 1);
    chk(!link_ack, "R6", "second request unanswered", {31'd0, link_ack}, '0);
    rdy_mode = 1;
    wait_drain("R6");
    chk(delivered == d0 + 2, "R6", "both words after release", delivered, d0 + 2);
  endtask

  task automatic test_stream(input int half, input int mode, input int count);
    int d0 = delivered;
    rx_half  = half;
    rdy_mode = mode;
    repeat (4) @(negedge rx_clk);
    for (int i = 0; i < count; i++) begin
      send($urandom);
      if ($urandom % 3 == 0) repeat ($urandom % 4) @(posedge tx_clk);
    end
    rdy_mode = 1;
    wait_drain("R7");
    chk(delivered == d0 + count, "R7", "stream count", delivered, d0 + count);
    chk(req_rises == delivered, "R8", "one request per word", req_rises, delivered);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    test_single();
    test_backpressure();
    test_stream(2, 1, 60);
    test_stream(19, 1, 40);
    test_stream(5, 2, 60);
    test_stream(13, 2, 50);
    test_stream(3, 2, 60);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule